// File: doc/BRIEF.md
# Coherence Request Dispatcher with Line-Address Conflict Screening

This block sits in front of the protocol engines of a memory controller. Coherence requests reach it from six sources. Five are hardware queues owned by the block: one from the local processor interface and four from the network virtual channels. The sixth is the head of a software-managed overflow queue that is held outside the block. Each cycle the dispatcher picks at most one request and writes it into a pending-work queue. The protocol engines read their work from that queue.

Two in-flight handlers must never work on the same directory entry. For this reason a request is held back while its cache-line address matches any entry in one of two places. The first is the outstanding-message buffer, which remembers every dispatched line until a completion pulse names it. The second is the pending-work queue. The five hardware queues are searched in full, so a blocked head does not stall younger, conflict-free entries behind it. Each queue closes the gap left by a removed entry. The software queue offers only its head. A round-robin pointer shares the dispatch slot among the six sources. When more than one engine asks for work in the same cycle, the lowest-numbered engine is served.

Every request stream uses valid/ready. On a hardware queue input, a request transfers on a clock edge where both valid and ready are high. Ready depends only on the fill level of that queue and falls when the queue is full. The software head is consumed on the edge where `sw_ready` is high. `sw_ready` is a dispatch decision made in the same cycle and is never high without `sw_valid`. The engine side works the same way: `eng_grant` is the ready of the engine whose `eng_req` is being served.

Top module: `cohd_dispatch`

## Requirements
- R1: After reset, all five hardware queues, the pending-work queue and the outstanding buffer are empty: `hq_ready` is all ones, `eng_valid` is 0 and `idle_cnt` is 0.
- R2: At most one request is dispatched per cycle. A dispatched request enters the tail of the pending-work queue together with its source code, and the queue presents requests in dispatch order on `eng_addr`/`eng_src`.
- R3: Source codes are 0 for the processor-interface queue, 1 to 4 for the virtual-channel queues and 5 for the software head. The first eligible source at or after a round-robin pointer wins. The pointer moves to the winner plus one (wrapping 5 to 0) only in a cycle with a dispatch, and it starts at 0.
- R4: The line address is bits AW-1 down to log2(line bytes). A candidate whose line matches a live outstanding-buffer entry is not dispatched.
- R5: A candidate whose line matches any entry of the pending-work queue is not dispatched, even if that entry leaves the queue in the same cycle.
- R6: Any entry of a hardware queue may be dispatched. Within a queue, the oldest conflict-free entry is chosen, and the remaining entries keep their order.
- R7: Only the head of the software queue is a candidate. `sw_ready` pulses for one cycle when it is dispatched.
- R8: A completion pulse frees the outstanding entry with the same line at the next edge. A candidate with that line is still blocked in the cycle of the pulse.
- R9: When `eng_valid` is high, the lowest-indexed engine with `eng_req` high receives a one-hot `eng_grant` and the head is removed. No grant is given when the queue is empty.
- R10: `hq_ready[i]` is low exactly when queue i holds its depth in entries. A valid request while ready is low is not taken.
- R11: No dispatch takes place in a cycle where the pending-work queue is full or the outstanding buffer is full, judged on the occupancy at the start of that cycle.
- R12: `idle_cnt` increases by one after every cycle in which some hardware queue holds an entry or `sw_valid` is high but nothing is dispatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hq_valid | input | 5 | Request offered to hardware queue i |
| hq_addr | input | 5 x AW | Request address for each hardware queue |
| hq_ready | output | 5 | Hardware queue i can accept a request |
| sw_valid | input | 1 | Software queue head is present |
| sw_addr | input | AW | Software queue head address |
| sw_ready | output | 1 | Software head is consumed this cycle |
| eng_req | input | NENG | Engine asks for work |
| eng_grant | output | NENG | One-hot grant; the head goes to this engine |
| eng_valid | output | 1 | Pending-work queue is not empty |
| eng_addr | output | AW | Address at the head of the pending-work queue |
| eng_src | output | 3 | Source code of the head request |
| done_valid | input | 1 | Completion pulse |
| done_addr | input | AW | Address whose line is released |
| idle_cnt | output | IDLE_W | Count of cycles with pending work but no dispatch |

## Verification
The bench goes after same-line pairs in one queue. A design that only screens the head, or that skips the pending-work queue, would put a second handler on a line that is still in flight. A blocked head with a free entry behind it shows whether the design stalls the whole queue instead of dispatching out of order. Completion pulses that arrive in the same cycle as a waiting same-line request catch a design that forwards the release a cycle early. Full pending-work and outstanding buffers catch a design that drops a request or overruns the buffer. Back-pressure at full depth and the order in which sources are served expose a pointer that moves on idle cycles or a queue that loses its order after a removal.

// File: rtl/cohd_pkg.sv
package cohd_pkg;
  localparam int NHQ    = 5;
  localparam int NSRC   = NHQ + 1;
  localparam int SRCW   = 3;
  localparam int SW_SRC = NHQ;
endpackage

// File: rtl/cohd_pick_low.sv
module cohd_pick_low #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/cohd_rr.sv
module cohd_rr #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic          gnt_vld,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] ptr;

  always_comb begin
    gnt_vld = 1'b0;
    gnt_idx = '0;
    // walk backwards so the smallest distance from ptr is kept last
    for (int k = N - 1; k >= 0; k--) begin
      if (req[(int'(ptr) + k) % N]) begin
        gnt_vld = 1'b1;
        gnt_idx = IW'((int'(ptr) + k) % N);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (gnt_vld) begin
      ptr <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + 1'b1;
    end
  end
endmodule

// File: rtl/cohd_cq.sv
module cohd_cq #(
  parameter int W     = 40,
  parameter int DEPTH = 8,
  parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push_valid,
  input  logic [W-1:0]               push_data,
  output logic                       push_ready,
  input  logic                       pop_en,
  input  logic [IW-1:0]              pop_idx,
  output logic [DEPTH-1:0][W-1:0]    ent_data,
  output logic [DEPTH-1:0]           ent_vld
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][W-1:0] mem;
  logic [CW-1:0]           cnt;
  logic                    push_fire;
  logic [IW-1:0]           wr_idx;

  assign push_ready = (cnt < CW'(DEPTH));
  assign push_fire  = push_valid && push_ready;
  assign wr_idx     = IW'(cnt - CW'(pop_en));
  assign ent_data   = mem;

  for (genvar j = 0; j < DEPTH; j++) begin : g_vld
    assign ent_vld[j] = (CW'(j) < cnt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      if (pop_en) begin
        for (int j = 0; j < DEPTH - 1; j++) begin
          if (j >= int'(pop_idx)) mem[j] <= mem[j+1];
        end
      end
      if (push_fire) mem[wr_idx] <= push_data;
      cnt <= cnt + CW'(push_fire) - CW'(pop_en);
    end
  end
endmodule

// File: rtl/cohd_omb.sv
module cohd_omb #(
  parameter int LW    = 33,
  parameter int DEPTH = 8,
  parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ins_en,
  input  logic [LW-1:0]            ins_line,
  input  logic                     clr_en,
  input  logic [LW-1:0]            clr_line,
  output logic [DEPTH-1:0][LW-1:0] tab_line,
  output logic [DEPTH-1:0]         tab_vld,
  output logic                     full
);
  logic [DEPTH-1:0][LW-1:0] line_q;
  logic [DEPTH-1:0]         vld_q;
  logic                     free_found;
  logic [IW-1:0]            free_idx;

  cohd_pick_low #(.N(DEPTH), .IW(IW)) u_free (
    .req   (~vld_q),
    .found (free_found),
    .idx   (free_idx)
  );

  assign tab_line = line_q;
  assign tab_vld  = vld_q;
  assign full     = &vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        if (clr_en && vld_q[k] && (line_q[k] == clr_line)) vld_q[k] <= 1'b0;
      end
      if (ins_en && free_found) begin
        vld_q[free_idx]  <= 1'b1;
        line_q[free_idx] <= ins_line;
      end
    end
  end
endmodule

// File: rtl/cohd_dispatch.sv
module cohd_dispatch
  import cohd_pkg::*;
#(
  parameter int AW         = 40,
  parameter int LINE_BYTES = 128,
  parameter int HQ_DEPTH   = 8,
  parameter int PWQ_DEPTH  = 8,
  parameter int OMB_DEPTH  = 8,
  parameter int NENG       = 2,
  parameter int IDLE_W     = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NHQ-1:0]           hq_valid,
  input  logic [NHQ-1:0][AW-1:0]   hq_addr,
  output logic [NHQ-1:0]           hq_ready,
  input  logic                     sw_valid,
  input  logic [AW-1:0]            sw_addr,
  output logic                     sw_ready,
  input  logic [NENG-1:0]          eng_req,
  output logic [NENG-1:0]          eng_grant,
  output logic                     eng_valid,
  output logic [AW-1:0]            eng_addr,
  output logic [SRCW-1:0]          eng_src,
  input  logic                     done_valid,
  input  logic [AW-1:0]            done_addr,
  output logic [IDLE_W-1:0]        idle_cnt
);
  localparam int OFFB = $clog2(LINE_BYTES);
  localparam int LW   = AW - OFFB;
  localparam int HIW  = (HQ_DEPTH > 1) ? $clog2(HQ_DEPTH) : 1;
  localparam int PIW  = (PWQ_DEPTH > 1) ? $clog2(PWQ_DEPTH) : 1;
  localparam int EIW  = (NENG > 1) ? $clog2(NENG) : 1;
  localparam int PW   = AW + SRCW;

  function automatic logic line_busy(
    input logic [LW-1:0]                  ln,
    input logic [OMB_DEPTH-1:0][LW-1:0]   ot,
    input logic [OMB_DEPTH-1:0]           ov,
    input logic [PWQ_DEPTH-1:0][PW-1:0]   pt,
    input logic [PWQ_DEPTH-1:0]           pv
  );
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < OMB_DEPTH; k++)
      if (ov[k] && (ot[k] == ln)) hit = 1'b1;
    for (int k = 0; k < PWQ_DEPTH; k++)
      if (pv[k] && (pt[k][AW-1:OFFB] == ln)) hit = 1'b1;
    return hit;
  endfunction

  // outstanding-message buffer and pending-work queue state
  logic [OMB_DEPTH-1:0][LW-1:0] omb_line;
  logic [OMB_DEPTH-1:0]         omb_vld;
  logic                         omb_full;
  logic [PWQ_DEPTH-1:0][PW-1:0] pwq_ent;
  logic [PWQ_DEPTH-1:0]         pwq_vld;
  logic                         pwq_ready;
  logic                         pwq_full;
  logic [PIW-1:0]               pwq_head;

  // dispatch path
  logic                         disp_fire;
  logic [SRCW-1:0]              disp_src;
  logic [AW-1:0]                disp_addr;
  logic                         issue_ok;
  logic                         sw_cand;
  logic [NSRC-1:0]              src_req;

  // hardware queues
  logic [HQ_DEPTH-1:0][AW-1:0]  hq_ent  [NHQ];
  logic [HQ_DEPTH-1:0]          hq_vld  [NHQ];
  logic [HQ_DEPTH-1:0]          hq_free [NHQ];
  logic [HIW-1:0]               hq_idx  [NHQ];
  logic [NHQ-1:0]               hq_cand;
  logic [NHQ-1:0]               hq_pop;

  // engine side
  logic [NENG-1:0]              eng_live;
  logic                         eng_take;
  logic [EIW-1:0]               eng_sel;

  logic                         pending;
  logic                         unused_lo;

  assign unused_lo = ^done_addr[OFFB-1:0];

  for (genvar q = 0; q < NHQ; q++) begin : g_hq
    cohd_cq #(.W(AW), .DEPTH(HQ_DEPTH), .IW(HIW)) u_hq (
      .clk        (clk),
      .rst        (rst),
      .push_valid (hq_valid[q]),
      .push_data  (hq_addr[q]),
      .push_ready (hq_ready[q]),
      .pop_en     (hq_pop[q]),
      .pop_idx    (hq_idx[q]),
      .ent_data   (hq_ent[q]),
      .ent_vld    (hq_vld[q])
    );

    for (genvar e = 0; e < HQ_DEPTH; e++) begin : g_ent
      assign hq_free[q][e] = hq_vld[q][e] &&
        !line_busy(hq_ent[q][e][AW-1:OFFB], omb_line, omb_vld, pwq_ent, pwq_vld);
    end

    cohd_pick_low #(.N(HQ_DEPTH), .IW(HIW)) u_oldest (
      .req   (hq_free[q]),
      .found (hq_cand[q]),
      .idx   (hq_idx[q])
    );

    assign hq_pop[q] = disp_fire && (disp_src == SRCW'(q));
  end

  assign sw_cand  = sw_valid &&
    !line_busy(sw_addr[AW-1:OFFB], omb_line, omb_vld, pwq_ent, pwq_vld);
  assign pwq_full = !pwq_ready;
  assign issue_ok = !pwq_full && !omb_full;
  assign src_req  = {sw_cand, hq_cand} & {NSRC{issue_ok}};

  cohd_rr #(.N(NSRC), .IW(SRCW)) u_rr (
    .clk     (clk),
    .rst     (rst),
    .req     (src_req),
    .gnt_vld (disp_fire),
    .gnt_idx (disp_src)
  );

  always_comb begin
    disp_addr = sw_addr;
    for (int q = 0; q < NHQ; q++) begin
      if (disp_src == SRCW'(q)) disp_addr = hq_ent[q][hq_idx[q]];
    end
  end

  assign sw_ready = disp_fire && (disp_src == SRCW'(SW_SRC));

  assign pwq_head = '0;

  cohd_cq #(.W(PW), .DEPTH(PWQ_DEPTH), .IW(PIW)) u_pwq (
    .clk        (clk),
    .rst        (rst),
    .push_valid (disp_fire),
    .push_data  ({disp_src, disp_addr}),
    .push_ready (pwq_ready),
    .pop_en     (eng_take),
    .pop_idx    (pwq_head),
    .ent_data   (pwq_ent),
    .ent_vld    (pwq_vld)
  );

  cohd_omb #(.LW(LW), .DEPTH(OMB_DEPTH)) u_omb (
    .clk      (clk),
    .rst      (rst),
    .ins_en   (disp_fire),
    .ins_line (disp_addr[AW-1:OFFB]),
    .clr_en   (done_valid),
    .clr_line (done_addr[AW-1:OFFB]),
    .tab_line (omb_line),
    .tab_vld  (omb_vld),
    .full     (omb_full)
  );

  assign eng_live = eng_req & {NENG{pwq_vld[0]}};

  cohd_pick_low #(.N(NENG), .IW(EIW)) u_eng_arb (
    .req   (eng_live),
    .found (eng_take),
    .idx   (eng_sel)
  );

  assign eng_grant = eng_take ? (NENG'(1) << eng_sel) : '0;
  assign eng_valid = pwq_vld[0];
  assign eng_addr  = pwq_ent[0][AW-1:0];
  assign eng_src   = pwq_ent[0][PW-1:AW];

  always_comb begin
    pending = sw_valid;
    for (int q = 0; q < NHQ; q++) pending = pending | hq_vld[q][0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_cnt <= '0;
    end else if (pending && !disp_fire) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cohd_dispatch_chk.sv
module cohd_dispatch_chk
  import cohd_pkg::*;
#(
  parameter int NENG   = 2,
  parameter int IDLE_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [NHQ-1:0]    hq_ready,
  input logic              sw_valid,
  input logic              sw_ready,
  input logic [NENG-1:0]   eng_req,
  input logic [NENG-1:0]   eng_grant,
  input logic              eng_valid,
  input logic [IDLE_W-1:0] idle_cnt,
  input logic              disp_fire,
  input logic              pwq_full,
  input logic [NHQ-1:0]    hq_pop
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (hq_ready == {NHQ{1'b1}}) && !eng_valid && (idle_cnt == '0));

  // R2
  one_dispatch_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({sw_ready, hq_pop}) <= 1);

  // R7
  sw_take_chk: assert property (@(posedge clk) disable iff (rst)
    sw_ready |-> sw_valid);

  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(eng_grant));

  // R9
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    (|eng_grant) |-> eng_valid && ((eng_grant & ~eng_req) == '0));

  // R11
  pwq_full_stall_chk: assert property (@(posedge clk) disable iff (rst)
    pwq_full |-> !disp_fire);

  // R12
  idle_step_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (idle_cnt == $past(idle_cnt)) || (idle_cnt == $past(idle_cnt) + 1'b1));
endmodule

bind cohd_dispatch cohd_dispatch_chk #(.NENG(NENG), .IDLE_W(IDLE_W)) u_chk (.*);

// File: tb/cohd_dispatch_bench.sv
module cohd_dispatch_bench;
  import cohd_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 40;
  localparam int OFFB = 7;
  localparam int HQD  = 8;
  localparam int PWQD = 8;
  localparam int OMBD = 8;
  localparam int NE   = 2;
  localparam int IDW  = 16;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic [NHQ-1:0]         hq_valid = '0;
  logic [NHQ-1:0][AW-1:0] hq_addr = '0;
  logic [NHQ-1:0]         hq_ready;
  logic                   sw_valid = 1'b0;
  logic [AW-1:0]          sw_addr = '0;
  logic                   sw_ready;
  logic [NE-1:0]          eng_req = '0;
  logic [NE-1:0]          eng_grant;
  logic                   eng_valid;
  logic [AW-1:0]          eng_addr;
  logic [SRCW-1:0]        eng_src;
  logic                   done_valid = 1'b0;
  logic [AW-1:0]          done_addr = '0;
  logic [IDW-1:0]         idle_cnt;

  cohd_dispatch u_cohd_dispatch (
    .clk(clk), .rst(rst), .hq_valid(hq_valid), .hq_addr(hq_addr), .hq_ready(hq_ready),
    .sw_valid(sw_valid), .sw_addr(sw_addr), .sw_ready(sw_ready),
    .eng_req(eng_req), .eng_grant(eng_grant), .eng_valid(eng_valid),
    .eng_addr(eng_addr), .eng_src(eng_src),
    .done_valid(done_valid), .done_addr(done_addr), .idle_cnt(idle_cnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  logic [AW-1:0] mq [NHQ][$];
  logic [AW-1:0] msw[$];
  logic [AW-1:0] pq_a[$];
  int            pq_s[$];
  logic [AW-1:0] momb[$];
  int            rr = 0;
  int            idle = 0;
  int            glog[$];

  int    nchk = 0;
  int    nerr = 0;
  string phase = "reset";

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s [%s] t=%0t: actual %0h expected %0h", tag, phase, $time, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(int line, int off);
    return (AW'(line) << OFFB) | AW'(off % 128);
  endfunction

  function automatic bit busy(logic [AW-1:0] a);
    foreach (momb[k]) if ((momb[k] >> OFFB) == (a >> OFFB)) return 1'b1;
    foreach (pq_a[k]) if ((pq_a[k] >> OFFB) == (a >> OFFB)) return 1'b1;
    return 1'b0;
  endfunction

  // one clock: compare at the falling edge, update the model after the rising edge
  task automatic step();
    logic [NHQ-1:0] rdy;
    int  dsrc, didx, g, pick;
    bit  can, pend;
    logic [AW-1:0] daddr;
    sw_valid = (msw.size() > 0);
    sw_addr  = (msw.size() > 0) ? msw[0] : '0;
    @(negedge clk);
    #1;
    for (int i = 0; i < NHQ; i++) rdy[i] = (mq[i].size() < HQD);
    can  = (pq_a.size() < PWQD) && (momb.size() < OMBD);
    dsrc = -1; didx = -1; daddr = '0;
    if (can) begin
      for (int k = 0; k < NSRC; k++) begin
        int s;
        s = (rr + k) % NSRC;
        if (dsrc < 0) begin
          if (s == SW_SRC) begin
            if (msw.size() > 0 && !busy(msw[0])) begin dsrc = s; daddr = msw[0]; end
          end else begin
            pick = -1;
            foreach (mq[s][e]) if (pick < 0 && !busy(mq[s][e])) pick = e;
            if (pick >= 0) begin dsrc = s; didx = pick; daddr = mq[s][pick]; end
          end
        end
      end
    end
    g = -1;
    if (pq_a.size() > 0) for (int e = NE - 1; e >= 0; e--) if (eng_req[e]) g = e;
    pend = (msw.size() > 0);
    for (int i = 0; i < NHQ; i++) if (mq[i].size() > 0) pend = 1'b1;

    check("R10 hq_ready", 64'(hq_ready), 64'(rdy));
    check("R7 sw_ready", 64'(sw_ready), 64'(dsrc == SW_SRC));
    check("R2 eng_valid", 64'(eng_valid), 64'(pq_a.size() > 0));
    if (pq_a.size() > 0) begin
      check("R2 eng_addr", 64'(eng_addr), 64'(pq_a[0]));
      check("R3 eng_src", 64'(eng_src), 64'(pq_s[0]));
    end
    check("R9 eng_grant", 64'(eng_grant), (g >= 0) ? (64'(1) << g) : 64'(0));
    check("R12 idle_cnt", 64'(idle_cnt), 64'(idle & 16'hffff));

    @(posedge clk);
    #1;
    if (g >= 0) begin
      glog.push_back(pq_s[0]);
      void'(pq_a.pop_front());
      void'(pq_s.pop_front());
    end
    if (done_valid) begin
      for (int k = momb.size() - 1; k >= 0; k--)
        if ((momb[k] >> OFFB) == (done_addr >> OFFB)) momb.delete(k);
    end
    if (dsrc >= 0) begin
      if (dsrc == SW_SRC) void'(msw.pop_front());
      else mq[dsrc].delete(didx);
      pq_a.push_back(daddr);
      pq_s.push_back(dsrc);
      momb.push_back(daddr);
      rr = (dsrc + 1) % NSRC;
    end else if (pend) begin
      idle++;
    end
    for (int i = 0; i < NHQ; i++) if (hq_valid[i] && rdy[i]) mq[i].push_back(hq_addr[i]);
  endtask

  task automatic quiet();
    hq_valid   = '0;
    done_valid = 1'b0;
  endtask

  task automatic drain();
    eng_req = '1;
    hq_valid = '0;
    for (int n = 0; n < 60; n++) begin
      done_valid = (momb.size() > 0);
      done_addr  = (momb.size() > 0) ? momb[0] : '0;
      step();
    end
    done_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    check("R1 hq_ready", 64'(hq_ready), 64'h1f);
    check("R1 eng_valid", 64'(eng_valid), 64'd0);
    check("R1 idle_cnt", 64'(idle_cnt), 64'd0);
    check("R1 sw_ready", 64'(sw_ready), 64'd0);
    @(posedge clk); #1;

    // R3: one request per source, served in code order from pointer 0
    phase = "R3_rr";
    glog.delete();
    eng_req = '1;
    for (int i = 0; i < NHQ; i++) begin hq_valid[i] = 1'b1; hq_addr[i] = mk(10 + i, i); end
    step();
    quiet();
    msw.push_back(mk(20, 3));
    for (int n = 0; n < 12; n++) step();
    check("R3 grant count", 64'(glog.size()), 64'd6);
    for (int i = 0; i < 6 && i < glog.size(); i++) check("R3 source order", 64'(glog[i]), 64'(i));

    // R4 / R5 / R8: same line twice in one queue
    phase = "R5_R4_R8_conflict";
    glog.delete();
    eng_req = '0;
    hq_valid[0] = 1'b1; hq_addr[0] = mk(30, 4);  step();
    hq_addr[0] = mk(30, 9);                      step();
    quiet();
    for (int n = 0; n < 3; n++) step();
    // release the buffer entry while the first copy still waits in the pending queue: R5 still blocks
    done_valid = 1'b1; done_addr = mk(30, 0); step();
    done_valid = 1'b0;
    for (int n = 0; n < 3; n++) step();
    check("R5 one entry waiting", 64'(eng_valid), 64'd1);
    eng_req = 2'b11; step();
    eng_req = '0;
    for (int n = 0; n < 3; n++) step();
    // second copy is now in the pending queue and the buffer
    eng_req = 2'b10; step();
    eng_req = '0;
    hq_valid[0] = 1'b1; hq_addr[0] = mk(30, 1); step();
    quiet();
    for (int n = 0; n < 3; n++) step();
    // R4: the buffer alone blocks the third copy; R8: still blocked in the pulse cycle
    check("R4 pending queue empty", 64'(eng_valid), 64'd0);
    done_valid = 1'b1; done_addr = mk(30, 2); step();
    done_valid = 1'b0;
    check("R8 blocked in pulse cycle", 64'(eng_valid), 64'd0);
    step();
    step();
    check("R8 dispatched after release", 64'(eng_valid), 64'd1);
    check("R9 grants in phase", 64'(glog.size()), 64'd2);
    drain();

    // R6: blocked older entry, younger free entry dispatches first
    phase = "R6_out_of_order";
    eng_req = '0;
    hq_valid[2] = 1'b1; hq_addr[2] = mk(40, 0); step();
    quiet();
    step();
    hq_valid[1] = 1'b1; hq_addr[1] = mk(40, 5); step();
    hq_addr[1] = mk(41, 0); step();
    hq_addr[1] = mk(42, 0); step();
    quiet();
    for (int n = 0; n < 4; n++) step();
    check("R6 older entry still held", 64'(mq[1].size()), 64'd1);
    drain();

    // R10: fill one queue behind a busy line
    phase = "R10_backpressure";
    eng_req = '0;
    hq_valid[3] = 1'b1;
    for (int n = 0; n < 11; n++) begin hq_addr[3] = mk(50, n); step(); end
    quiet();
    #1;
    check("R10 queue full ready low", 64'(hq_ready[3]), 64'd0);
    drain();

    // R11: pending queue fills with engines idle
    phase = "R11_pwq_full";
    eng_req = '0;
    for (int n = 0; n < 4; n++) begin
      for (int i = 0; i < NHQ; i++) begin hq_valid[i] = 1'b1; hq_addr[i] = mk(60 + n * 8 + i, n); end
      step();
    end
    quiet();
    for (int n = 0; n < 12; n++) step();
    check("R11 pending queue capped", 64'(pq_a.size()), 64'(PWQD));
    drain();

    // R11: outstanding buffer fills while engines drain the queue
    phase = "R11_omb_full";
    eng_req = '1;
    for (int n = 0; n < 2; n++) begin
      for (int i = 0; i < NHQ; i++) begin hq_valid[i] = 1'b1; hq_addr[i] = mk(100 + n * 8 + i, 0); end
      step();
    end
    quiet();
    for (int n = 0; n < 15; n++) step();
    check("R11 buffer capped", 64'(momb.size()), 64'(OMBD));
    drain();

    // mixed traffic on a small set of lines
    phase = "R6_R7_random";
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < NHQ; i++) begin
        hq_valid[i] = ($urandom_range(0, 3) == 0);
        hq_addr[i]  = mk($urandom_range(0, 9), $urandom_range(0, 127));
      end
      if ($urandom_range(0, 7) == 0 && msw.size() < 4)
        msw.push_back(mk($urandom_range(0, 9), $urandom_range(0, 127)));
      eng_req = NE'($urandom_range(0, 3));
      done_valid = 1'b0;
      if (momb.size() > 0 && $urandom_range(0, 2) == 0) begin
        done_valid = 1'b1;
        done_addr  = momb[$urandom_range(0, momb.size() - 1)] ^ AW'($urandom_range(0, 127));
      end else if ($urandom_range(0, 9) == 0) begin
        done_valid = 1'b1;
        done_addr  = mk($urandom_range(0, 9), 0);
      end
      step();
    end
    drain();

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule